// File: doc/BRIEF.md
# DRAM Page-Hit Detector

This block sits on the outgoing memory address stream of a processor bus interface. For every access it checks whether the address lies in the same DRAM row as the most recent earlier access. When it does, it pulls an active-low "near" hint low in the same cycle as the access. A page-mode or static-column memory controller can use that hint to skip a new row activation and issue only a column cycle.

The row size is not fixed. A two-bit page-size setting, written by software into a control field, chooses how many low address bits the row comparison ignores. Encoding 0 gives 512-byte rows, 1 gives 1 KiB, 2 gives 2 KiB and 3 gives 4 KiB. The detector keeps one reference address. Only a valid access replaces that address. Any change of the page-size setting discards the reference, so the detector never reports a hit against a row that was measured under another size.

Top module: `page_hit_det`

## Requirements
- R1: After synchronous reset, `near_n` is 1 while reset is held and for the first valid access that follows.
- R2: In any cycle where `addr_vld` is 0, `near_n` is 1, whatever the value on `addr`.
- R3: A valid access whose address agrees with the reference address in every bit at or above position 9 + `pg_size` drives `near_n` to 0 in that same cycle, provided the reference exists and `pg_size` did not change.
- R4: A valid access whose address differs from the reference in any bit at or above position 9 + `pg_size` drives `near_n` to 1.
- R5: `pg_size` encodings 0, 1, 2 and 3 select rows of 512, 1024, 2048 and 4096 bytes. Address bits below 9 + `pg_size` never affect the result.
- R6: If `pg_size` in a cycle differs from its value in the previous cycle, `near_n` is 1 in that cycle. Once the new setting is in force, the first valid access is also reported as not near, unless that access occurred in the very cycle of the change, in which case it becomes the reference.
- R7: The reference address changes only on cycles with `addr_vld` = 1. Addresses presented while `addr_vld` = 0 are ignored.
- R8: Every valid access replaces the reference, so a row accessed two accesses back does not produce a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_vld | input | 1 | High in each cycle that carries a bus access |
| addr | input | 32 | Byte address of the access |
| pg_size | input | 2 | Row-size select: 0=512 B, 1=1 KiB, 2=2 KiB, 3=4 KiB |
| near_n | output | 1 | Low when the current access hits the reference row |

## Verification
A bound checker keeps its own shadow of the last valid address and the last page-size setting. On every cycle it checks that idle cycles keep the hint high, that a size change forces it high, that no hint appears before the first access after reset, and that a low hint occurs exactly when the masked rows match. Several behaviours can only be shown by the bench's scenarios. These are the exact row boundary for each size encoding, a size change that is reverted before any access, and a far address shown during idle cycles followed by an access near the older reference. The bench drives these cases directly and adds a long stream of seeded random accesses biased towards row hits.

// File: rtl/pgdet_pkg.sv
`timescale 1ns/1ps
package pgdet_pkg;

    localparam int ADDR_W  = 32;
    localparam int SEL_W   = 2;
    localparam int BASE_LG = 9;

    typedef enum logic [SEL_W-1:0] {
        PG_512 = 2'd0,
        PG_1K  = 2'd1,
        PG_2K  = 2'd2,
        PG_4K  = 2'd3
    } pg_sel_e;

    typedef struct packed {
        logic              ok;
        logic [ADDR_W-1:0] addr;
    } ref_t;

    function automatic int row_lsb(input logic [SEL_W-1:0] sel, input int base);
        return base + int'(sel);
    endfunction

endpackage

// File: rtl/pgdet_cfg_track.sv
`timescale 1ns/1ps
module pgdet_cfg_track #(
    parameter int SEL_W = pgdet_pkg::SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel_i,
    output logic [SEL_W-1:0] sel_q_o,
    output logic             changed_o
);
    logic [SEL_W-1:0] sel_q;

    always_ff @(posedge clk) begin
        sel_q <= sel_i;
    end

    assign sel_q_o   = sel_q;
    assign changed_o = rst ? 1'b0 : (sel_i != sel_q);

endmodule

// File: rtl/pgdet_ref_store.sv
`timescale 1ns/1ps
module pgdet_ref_store #(
    parameter int ADDR_W = pgdet_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vld_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              changed_i,
    output logic [ADDR_W-1:0] ref_addr_o,
    output logic              ref_ok_o
);
    logic              ok_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ok_q   <= 1'b0;
            addr_q <= '0;
        end else if (vld_i) begin
            ok_q   <= 1'b1;
            addr_q <= addr_i;
        end else if (changed_i) begin
            ok_q   <= 1'b0;
        end
    end

    assign ref_addr_o = addr_q;
    assign ref_ok_o   = ok_q;

endmodule

// File: rtl/pgdet_row_cmp.sv
`timescale 1ns/1ps
module pgdet_row_cmp #(
    parameter int ADDR_W  = pgdet_pkg::ADDR_W,
    parameter int SEL_W   = pgdet_pkg::SEL_W,
    parameter int BASE_LG = pgdet_pkg::BASE_LG
) (
    input  logic [ADDR_W-1:0] a_i,
    input  logic [ADDR_W-1:0] b_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic              same_row_o
);
    logic [ADDR_W-1:0] diff_bits;
    int                lsb;

    assign lsb = pgdet_pkg::row_lsb(sel_i, BASE_LG);

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign diff_bits[i] = (a_i[i] ^ b_i[i]) & (i >= lsb);
    end

    assign same_row_o = ~|diff_bits;

endmodule

// File: rtl/page_hit_det.sv
`timescale 1ns/1ps
module page_hit_det #(
    parameter int ADDR_W  = pgdet_pkg::ADDR_W,
    parameter int SEL_W   = pgdet_pkg::SEL_W,
    parameter int BASE_LG = pgdet_pkg::BASE_LG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_vld,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SEL_W-1:0]  pg_size,
    output logic              near_n
);
    logic [SEL_W-1:0]  sel_q;
    logic              size_changed;
    logic [ADDR_W-1:0] ref_addr;
    logic              ref_ok;
    logic              same_row;

    pgdet_cfg_track #(.SEL_W(SEL_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .sel_i     (pg_size),
        .sel_q_o   (sel_q),
        .changed_o (size_changed)
    );

    pgdet_ref_store #(.ADDR_W(ADDR_W)) u_ref (
        .clk        (clk),
        .rst        (rst),
        .vld_i      (addr_vld),
        .addr_i     (addr),
        .changed_i  (size_changed),
        .ref_addr_o (ref_addr),
        .ref_ok_o   (ref_ok)
    );

    pgdet_row_cmp #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .BASE_LG(BASE_LG)) u_cmp (
        .a_i        (addr),
        .b_i        (ref_addr),
        .sel_i      (pg_size),
        .same_row_o (same_row)
    );

    assign near_n = ~(addr_vld & ref_ok & ~size_changed & same_row & ~rst);

endmodule

// File: rtl/page_hit_det_chk.sv
`timescale 1ns/1ps
module page_hit_det_chk #(
    parameter int ADDR_W  = pgdet_pkg::ADDR_W,
    parameter int SEL_W   = pgdet_pkg::SEL_W,
    parameter int BASE_LG = pgdet_pkg::BASE_LG
) (
    input logic              clk,
    input logic              rst,
    input logic              addr_vld,
    input logic [ADDR_W-1:0] addr,
    input logic [SEL_W-1:0]  pg_size,
    input logic              near_n
);
    logic              seen_q;
    logic [ADDR_W-1:0] last_q;
    logic [SEL_W-1:0]  sel_q;
    logic              row_eq;
    logic              sel_moved;

    always_ff @(posedge clk) begin
        sel_q <= pg_size;
        if (rst) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (addr_vld) begin
            seen_q <= 1'b1;
            last_q <= addr;
        end else if (pg_size != sel_q) begin
            seen_q <= 1'b0;
        end
    end

    assign sel_moved = (pg_size != sel_q);
    assign row_eq    = ((addr ^ last_q) >> (BASE_LG + int'(pg_size))) == '0;

    // R2: idle cycles never carry a hint
    p_idle_high_r2: assert property (@(posedge clk) disable iff (rst)
        !addr_vld |-> near_n);

    // R1: no hint before a reference exists
    p_no_ref_no_hint_r1: assert property (@(posedge clk) disable iff (rst)
        !seen_q |-> near_n);

    // R6: a size change suppresses the hint in that cycle
    p_size_change_r6: assert property (@(posedge clk) disable iff (rst)
        sel_moved |-> near_n);

    // R3: matching row with stable size must hit
    p_hit_r3: assert property (@(posedge clk) disable iff (rst)
        (addr_vld && seen_q && !sel_moved && row_eq) |-> !near_n);

    // R4: a hint implies the masked rows agree
    p_miss_r4: assert property (@(posedge clk) disable iff (rst)
        !near_n |-> (addr_vld && row_eq));

endmodule

bind page_hit_det page_hit_det_chk #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .BASE_LG(BASE_LG)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr_vld (addr_vld),
    .addr     (addr),
    .pg_size  (pg_size),
    .near_n   (near_n)
);

// File: tb/page_hit_det_tb_top.sv
`timescale 1ns/1ps
module page_hit_det_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_vld = 1'b0;
    logic [31:0] addr = '0;
    logic [1:0]  pg_size = 2'd0;
    logic        near_n;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // model state
    bit          m_ok = 1'b0;
    logic [31:0] m_ref = '0;
    logic [1:0]  m_sel = 2'd0;

    always #2.5 clk = ~clk;

    page_hit_det dut_i (
        .clk(clk), .rst(rst), .addr_vld(addr_vld),
        .addr(addr), .pg_size(pg_size), .near_n(near_n)
    );

    function automatic bit same_row(input logic [31:0] a, input logic [31:0] b,
                                    input logic [1:0] s);
        return ((a ^ b) >> (9 + int'(s))) == 32'd0;
    endfunction

    function automatic bit exp_near_n(input bit v, input logic [31:0] a, input logic [1:0] s);
        if (v && m_ok && (s == m_sel) && same_row(a, m_ref, s)) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(input string tag, input bit exp);
        tests++;
        if (near_n !== exp) begin
            fails++;
            $display("FAIL %s: near_n=%0b expected %0b (addr=%h sel=%0d vld=%0b)",
                     tag, near_n, exp, addr, pg_size, addr_vld);
        end
    endtask

    task automatic step(input bit v, input logic [31:0] a, input logic [1:0] s,
                        input string tag);
        bit e;
        @(negedge clk);
        addr_vld = v; addr = a; pg_size = s;
        #1;
        e = exp_near_n(v, a, s);
        check(tag, e);
        if (s != m_sel) m_ok = v;
        else if (v)     m_ok = 1'b1;
        if (v) m_ref = a;
        m_sel = s;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: run did not complete, expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        // reset with a valid access present: R1
        rst = 1'b1; addr_vld = 1'b1; addr = 32'h1000_0000; pg_size = 2'd0;
        repeat (3) @(negedge clk);
        #1 check("R1 during reset", 1'b1);
        @(negedge clk);
        rst = 1'b0; addr_vld = 1'b0;
        m_ok = 1'b0; m_sel = 2'd0;

        step(1, 32'h1000_0000, 2'd0, "R1 first access");
        step(1, 32'h1000_0004, 2'd0, "R3 same row");
        step(1, 32'h1000_01FF, 2'd0, "R5 512B top byte");
        step(1, 32'h1000_0200, 2'd0, "R4 R5 bit9 differs");
        step(1, 32'h1000_0200, 2'd3, "R6 size change cycle");
        step(1, 32'h1000_0A00, 2'd3, "R5 4K same row");
        step(1, 32'h1000_1000, 2'd3, "R4 4K boundary");
        step(1, 32'h1000_1400, 2'd1, "R6 change to 1K");
        step(1, 32'h1000_17FC, 2'd1, "R5 1K same row");
        step(1, 32'h1000_1800, 2'd2, "R6 change to 2K");
        step(1, 32'h1000_1FFC, 2'd2, "R5 2K same row");
        step(1, 32'h1000_2000, 2'd2, "R4 2K boundary");
        step(0, 32'h1000_2004, 2'd2, "R2 idle same row");
        step(0, 32'h7777_0000, 2'd2, "R2 R7 idle far addr");
        step(1, 32'h1000_2100, 2'd2, "R7 ref kept");
        step(1, 32'h8000_0000, 2'd2, "R4 far row");
        step(1, 32'h1000_2104, 2'd2, "R8 older row no hit");
        step(0, 32'h1000_2108, 2'd0, "R6 change while idle");
        step(0, 32'h1000_2108, 2'd2, "R6 revert while idle");
        step(1, 32'h1000_2108, 2'd2, "R6 ref dropped");
        step(1, 32'h1000_210C, 2'd2, "R3 hit after reseed");

        for (int i = 0; i < 4000; i++) begin
            bit          v;
            logic [1:0]  s;
            logic [31:0] a;
            string       tag;
            v = ($urandom_range(0, 9) != 0);
            s = ($urandom_range(0, 19) == 0) ? 2'($urandom_range(0, 3)) : m_sel;
            case ($urandom_range(0, 3))
                0:       a = $urandom;
                1:       a = m_ref ^ (32'd1 << $urandom_range(9, 13));
                default: a = m_ref ^ ($urandom & 32'h0000_01FF);
            endcase
            if (!v)             tag = "R2 random idle";
            else if (s != m_sel) tag = "R6 random change";
            else                tag = "R3 R4 random access";
            step(v, a, s, tag);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule